// File: doc/BRIEF.md
# Slope-Mode Ramp Pattern Generator

This block drives a pair of low-resistance focus outputs with a pulse pattern whose density climbs linearly, holds, falls linearly and holds again. When the pattern passes through a series inductor into a capacitive piezo element, the filtered voltage takes a rhombic or triangular shape instead of a square edge. This limits the current surges that hard edges would cause. A two-bit selector picks the ramp parameter X from 8, 9, 10 or 11. A period value sets the total length of one waveform in base units. A shared prescaler sets the length of a base unit in clocks. A step count sets how many complete waveforms one move produces.

A move begins with a one-cycle `start` in state IDLE. The controller samples all configuration at that edge. It then walks the states RISE, TOP, FALL and BOTTOM for each waveform and returns to IDLE after the last one. The transitions are:
- IDLE to RISE on an accepted start.
- RISE to TOP at the end of the last rising sub-period, or RISE to FALL when the plateau is empty.
- TOP to FALL when the plateau count is spent.
- FALL to BOTTOM at the end of the last falling sub-period. When the plateau is empty, FALL instead goes to RISE for the next waveform or to IDLE after the last one.
- BOTTOM to RISE for the next waveform, or to IDLE after the last one.

`drv_a` carries the pattern and `drv_b` its complement. A swap input, sampled at start, exchanges the two roles so the motor runs in the other direction.

Top module: `slope_ramp_gen`

## Requirements
- R1: After reset the block is idle. `drv_a`, `drv_b`, `busy` and `done` are all 0, and both drive outputs stay 0 whenever the block is idle.
- R2: `ramp_sel` values 0, 1, 2 and 3 select the ramp parameter X = 8, 9, 10 and 11.
- R3: The rising ramp is X sub-periods of X base units each. In sub-period k (k = 1..X) the pattern is high for the first k units and low for the rest.
- R4: After the rising ramp the pattern is high for P base units, where P = floor((period − 2·X²)/2). P is 0 when period < 2·X², and the top state is then skipped.
- R5: The falling ramp is X sub-periods of X units. In sub-period k (k = 1..X) the pattern is high for the first X−k units.
- R6: After the falling ramp the pattern is low for P base units.
- R7: Every base unit lasts `unit_div`+1 clock cycles. The pattern changes only at unit boundaries.
- R8: While busy with swap=0, `drv_a` equals the pattern and `drv_b` its complement. With swap=1 the two are exchanged.
- R9: `busy` is 1 from the cycle after an accepted start. After `step_count` complete waveforms, `busy` returns to 0 and `done` is 1 for exactly one cycle, in the first cycle after the last unit.
- R10: `start` has no effect while busy, and none when `step_count` is 0.
- R11: `ramp_sel`, `period`, `unit_div`, `step_count` and `swap` are sampled only at the accepted start. Changing them during a move does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a move (accepted only when idle) |
| ramp_sel | input | 2 | Ramp parameter select, X = 8 + ramp_sel |
| period | input | PW | Total waveform length in base units |
| unit_div | input | DW | Base unit length minus one, in clocks |
| step_count | input | SW | Number of waveforms per move |
| swap | input | 1 | Exchange the roles of the two drive outputs |
| drv_a | output | 1 | First focus drive output |
| drv_b | output | 1 | Second focus drive output |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle pulse at the end of a move |

## Verification
The embedded assertions check several properties on every cycle:
- the sub-period and unit counters stay within X;
- the prescaler count never passes the sampled divider;
- the drive outputs hold still between unit ticks;
- TOP is bypassed only when the plateau is empty;
- configuration is stable while a start arrives during a move;
- `done` lasts a single cycle.

Some behaviour only the bench's sweeps can show. These are the exact high-unit count in each sub-period, the plateau lengths at and around the 2·X² threshold, the number of repeated waveforms, and the roles of the outputs under swap. The bench compares every cycle of each move against an arithmetic model for all four X values and several periods and dividers.

// File: rtl/slope_pkg.sv
package slope_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RISE,
        ST_TOP,
        ST_FALL,
        ST_BOTTOM
    } slope_state_e;

    localparam int unsigned RAMP_BASE = 8;

    // Ramp parameter from the two-bit selector: 8, 9, 10, 11.
    function automatic logic [3:0] ramp_decode(input logic [1:0] sel);
        return 4'd8 + {2'b00, sel};
    endfunction

endpackage

// File: rtl/slope_prescaler.sv
module slope_prescaler #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          tick
);
    localparam logic [DW-1:0] CNT_ONE = DW'(1);

    logic [DW-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_ONE;
        end
    end

    // R7
    div_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= div));

endmodule

// File: rtl/slope_plateau.sv
module slope_plateau #(
    parameter int PW = 10
) (
    input  logic [3:0]    ramp_x,
    input  logic [PW-1:0] period,
    output logic [PW-1:0] plateau
);
    logic [7:0]  sq;
    logic [PW:0] both_ramps;
    logic [PW:0] per_ext;
    logic [PW:0] left;

    always_comb begin
        sq         = {4'b0000, ramp_x} * {4'b0000, ramp_x};
        both_ramps = (PW+1)'({sq, 1'b0});
        per_ext    = {1'b0, period};
        if (per_ext >= both_ramps) begin
            left = per_ext - both_ramps;
        end else begin
            left = '0;
        end
        plateau = left[PW:1];
    end

endmodule

// File: rtl/slope_fsm.sv
module slope_fsm
    import slope_pkg::*;
#(
    parameter int PW = 10,
    parameter int DW = 8,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    x_in,
    input  logic [PW-1:0] plat_in,
    input  logic [DW-1:0] div_in,
    input  logic [SW-1:0] steps_in,
    input  logic          swap_in,
    input  logic          tick,
    output logic          go,
    output logic          busy,
    output logic          pattern,
    output logic          swap_q,
    output logic [DW-1:0] div_q,
    output logic          done
);
    localparam logic [3:0]    X_ONE = 4'd1;
    localparam logic [PW-1:0] P_ONE = PW'(1);
    localparam logic [SW-1:0] S_ONE = SW'(1);

    slope_state_e  state;
    logic [3:0]    x_q;
    logic [3:0]    unit_cnt;
    logic [3:0]    sub_k;
    logic [PW-1:0] plat_q;
    logic [PW-1:0] plat_cnt;
    logic [SW-1:0] steps_q;
    logic [SW-1:0] step_cnt;

    logic unit_last;
    logic sub_last;
    logic plat_last;
    logic step_last;
    logic plat_empty;

    assign go         = start && (state == ST_IDLE) && (steps_in != '0);
    assign busy       = (state != ST_IDLE);
    assign unit_last  = (unit_cnt == x_q - X_ONE);
    assign sub_last   = (sub_k == x_q);
    assign plat_last  = (plat_cnt == plat_q - P_ONE);
    assign step_last  = (step_cnt == steps_q - S_ONE);
    assign plat_empty = (plat_q == '0);

    // State register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            x_q      <= 4'd8;
            unit_cnt <= '0;
            sub_k    <= X_ONE;
            plat_q   <= '0;
            plat_cnt <= '0;
            steps_q  <= '0;
            step_cnt <= '0;
            swap_q   <= 1'b0;
            div_q    <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (go) begin
                        x_q      <= x_in;
                        plat_q   <= plat_in;
                        div_q    <= div_in;
                        steps_q  <= steps_in;
                        swap_q   <= swap_in;
                        unit_cnt <= '0;
                        sub_k    <= X_ONE;
                        plat_cnt <= '0;
                        step_cnt <= '0;
                        state    <= ST_RISE;
                    end
                end
                ST_RISE: begin
                    if (tick) begin
                        if (unit_last) begin
                            unit_cnt <= '0;
                            if (sub_last) begin
                                sub_k <= X_ONE;
                                state <= plat_empty ? ST_FALL : ST_TOP;
                            end else begin
                                sub_k <= sub_k + X_ONE;
                            end
                        end else begin
                            unit_cnt <= unit_cnt + X_ONE;
                        end
                    end
                end
                ST_TOP: begin
                    if (tick) begin
                        if (plat_last) begin
                            plat_cnt <= '0;
                            state    <= ST_FALL;
                        end else begin
                            plat_cnt <= plat_cnt + P_ONE;
                        end
                    end
                end
                ST_FALL: begin
                    if (tick) begin
                        if (unit_last) begin
                            unit_cnt <= '0;
                            if (sub_last) begin
                                sub_k <= X_ONE;
                                if (!plat_empty) begin
                                    state <= ST_BOTTOM;
                                end else if (step_last) begin
                                    state <= ST_IDLE;
                                    done  <= 1'b1;
                                end else begin
                                    step_cnt <= step_cnt + S_ONE;
                                    state    <= ST_RISE;
                                end
                            end else begin
                                sub_k <= sub_k + X_ONE;
                            end
                        end else begin
                            unit_cnt <= unit_cnt + X_ONE;
                        end
                    end
                end
                ST_BOTTOM: begin
                    if (tick) begin
                        if (plat_last) begin
                            plat_cnt <= '0;
                            if (step_last) begin
                                state <= ST_IDLE;
                                done  <= 1'b1;
                            end else begin
                                step_cnt <= step_cnt + S_ONE;
                                state    <= ST_RISE;
                            end
                        end else begin
                            plat_cnt <= plat_cnt + P_ONE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Pattern output
    always_comb begin
        unique case (state)
            ST_IDLE:   pattern = 1'b0;
            ST_RISE:   pattern = (unit_cnt < sub_k);
            ST_TOP:    pattern = 1'b1;
            ST_FALL:   pattern = (unit_cnt < (x_q - sub_k));
            ST_BOTTOM: pattern = 1'b0;
            default:   pattern = 1'b0;
        endcase
    end

    // R3
    sub_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((sub_k != 4'd0) && (sub_k <= x_q) && (unit_cnt < x_q)));

    // R4
    top_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_FALL) && ($past(state) == ST_RISE)) |-> (plat_q == '0));

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(x_q) && $stable(plat_q) && $stable(steps_q)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/slope_drive_out.sv
module slope_drive_out (
    input  logic busy,
    input  logic pattern,
    input  logic swap_q,
    output logic drv_a,
    output logic drv_b
);
    always_comb begin
        if (!busy) begin
            drv_a = 1'b0;
            drv_b = 1'b0;
        end else if (swap_q) begin
            drv_a = ~pattern;
            drv_b = pattern;
        end else begin
            drv_a = pattern;
            drv_b = ~pattern;
        end
    end

endmodule

// File: rtl/slope_ramp_gen.sv
module slope_ramp_gen
    import slope_pkg::*;
#(
    parameter int PW = 10,
    parameter int DW = 8,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    ramp_sel,
    input  logic [PW-1:0] period,
    input  logic [DW-1:0] unit_div,
    input  logic [SW-1:0] step_count,
    input  logic          swap,
    output logic          drv_a,
    output logic          drv_b,
    output logic          busy,
    output logic          done
);
    logic [3:0]    x_in;
    logic [PW-1:0] plat_in;
    logic          go;
    logic          tick;
    logic          pattern;
    logic          swap_q;
    logic [DW-1:0] div_q;

    assign x_in = ramp_decode(ramp_sel);

    slope_plateau #(.PW(PW)) u_plateau (
        .ramp_x  (x_in),
        .period  (period),
        .plateau (plat_in)
    );

    slope_prescaler #(.DW(DW)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (go),
        .run   (busy),
        .div   (div_q),
        .tick  (tick)
    );

    slope_fsm #(.PW(PW), .DW(DW), .SW(SW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .x_in     (x_in),
        .plat_in  (plat_in),
        .div_in   (unit_div),
        .steps_in (step_count),
        .swap_in  (swap),
        .tick     (tick),
        .go       (go),
        .busy     (busy),
        .pattern  (pattern),
        .swap_q   (swap_q),
        .div_q    (div_q),
        .done     (done)
    );

    slope_drive_out u_drive (
        .busy    (busy),
        .pattern (pattern),
        .swap_q  (swap_q),
        .drv_a   (drv_a),
        .drv_b   (drv_b)
    );

    // R7
    unit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> ($stable(drv_a) && $stable(drv_b)));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!drv_a && !drv_b));

endmodule

// File: tb/sim_slope_ramp_gen.sv
module sim_slope_ramp_gen;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 10;
    localparam int DW = 8;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    ramp_sel = '0;
    logic [PW-1:0] period = '0;
    logic [DW-1:0] unit_div = '0;
    logic [SW-1:0] step_count = '0;
    logic          swap = 1'b0;
    logic          drv_a, drv_b, busy, done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slope_ramp_gen #(.PW(PW), .DW(DW), .SW(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ramp_sel(ramp_sel),
        .period(period), .unit_div(unit_div), .step_count(step_count),
        .swap(swap), .drv_a(drv_a), .drv_b(drv_b), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int plat_of(input int x, input int per);
        return (per >= 2*x*x) ? (per - 2*x*x) / 2 : 0;
    endfunction

    // Expected pattern level for unit u of one waveform
    function automatic bit level_of(input int x, input int p, input int u);
        int v;
        if (u < x*x) return (u % x) < (u / x + 1);         // R3 rise
        if (u < x*x + p) return 1'b1;                      // R4 top
        if (u < 2*x*x + p) begin                           // R5 fall
            v = u - x*x - p;
            return (v % x) < (x - (v / x + 1));
        end
        return 1'b0;                                       // R6 bottom
    endfunction

    task automatic run_case(input logic [1:0] xs, input int per, input int dv,
                            input int st, input bit sw);
        int x, p, n, d, total;
        bit lv;
        int exp_v, act_v;
        x = 8 + int'(xs);
        p = plat_of(x, per);
        n = 2*x*x + 2*p;
        d = dv + 1;
        total = n * st * d;
        @(negedge clk);
        ramp_sel = xs; period = PW'(per); unit_div = DW'(dv);
        step_count = SW'(st); swap = sw; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < total; i++) begin
            lv = level_of(x, p, (i / d) % n);
            exp_v = {1'b1, (sw ? ~lv : lv), (sw ? lv : ~lv)};
            act_v = {busy, drv_a, drv_b};
            check(act_v == exp_v, "R2 R3 R4 R5 R6 R7 R8 R11 pattern", act_v, exp_v);
            if (i == 3) begin
                // R10 R11: start and new config mid-move must be ignored
                start = 1'b1; ramp_sel = xs + 2'd1; period = PW'(per + 40);
                unit_div = DW'(dv + 1); step_count = SW'(st + 1); swap = ~sw;
            end
            if (i == 4) start = 1'b0;
            @(negedge clk);
        end
        act_v = {done, busy, drv_a, drv_b};
        check(act_v == 8, "R9 end of move", act_v, 8);
        @(negedge clk);
        act_v = {done, busy};
        check(act_v == 0, "R9 done single cycle", act_v, 0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int tw;
        int pers[6];
        repeat (3) @(negedge clk);
        // R1 reset state
        check({drv_a, drv_b, busy, done} == 0, "R1 reset state",
              int'({drv_a, drv_b, busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({drv_a, drv_b, busy, done} == 0, "R1 idle after reset",
              int'({drv_a, drv_b, busy, done}), 0);

        // R10 start with zero step count is ignored
        ramp_sel = 2'd1; period = PW'(300); step_count = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            check({busy, drv_a, drv_b, done} == 0, "R10 zero steps ignored",
                  int'({busy, drv_a, drv_b, done}), 0);
            @(negedge clk);
        end

        for (int xi = 0; xi < 4; xi++) begin
            tw = 2 * (8 + xi) * (8 + xi);
            pers[0] = 0; pers[1] = tw - 1; pers[2] = tw;
            pers[3] = tw + 1; pers[4] = tw + 7; pers[5] = 1023;
            for (int pi = 0; pi < 6; pi++) begin
                run_case(2'(xi), pers[pi], 0, 2, xi[0]);
                run_case(2'(xi), pers[pi], 2, 1, ~xi[0]);
            end
        end

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule